// File: doc/BRIEF.md
# Latch-Committed Serial Configuration Register Bank

This block takes configuration words from a three-wire serial port: data, serial clock and a latch strobe. It keeps them in a bank of sixteen 28-bit registers. A word is 32 bits long and is shifted in most significant bit first while the latch strobe is low. A rising edge of the latch strobe then commits the last 32 bits received. The low nibble of the word selects the register, and the upper 28 bits are the value stored there. The serial pins are asynchronous to the system clock, so they are synchronized first and their edges are detected in the system clock domain.

Some writes have side effects. A write to register 7 with word bit 4 set is a soft reset. It returns every register to its default value, drops the rest of that word, and pulses a reset output for one cycle. A write to register 15 pulses a calibration-start output for one cycle. A write to register 11 that changes the divider field (data bits 17:0, word bits 21:4) pulses the same output.

Top module: `cfg_serial_slave`

## Requirements
- R1: On a commit, the 28-bit value in word bits 31:4 is stored in the register numbered by word bits 3:0. Register n appears on `cfg_regs_o[n*28 +: 28]`.
- R2: Serial data is taken on each rising serial clock edge, most significant bit first, so the first bit shifted becomes word bit 31.
- R3: Serial clock edges that arrive while the latch strobe is high do not change the shift contents. A second latch pulse with no new low-phase bits commits the same word again.
- R4: Only the last 32 bits shifted before the latch edge form the word; earlier bits are discarded.
- R5: A committed word with address 7 and bit 4 set loads every register with its default. The rest of that word is stored nowhere.
- R6: A committed word with address 7 and bit 4 clear is stored as an ordinary write and does not pulse the reset output.
- R7: Each write to register 15 gives exactly one calibration-start pulse, one system clock cycle wide.
- R8: A write to register 11 gives exactly one calibration-start pulse when it changes data bits 17:0, and none when those bits are unchanged. Writes to other registers (other than 15) give no pulse.
- R9: Each soft-reset write gives exactly one reset pulse, one system clock cycle wide, and no calibration pulse.
- R10: After the system reset every register holds its default, and both pulse outputs are low. The default of register n is the 4-bit value n repeated seven times.
- R11: A write changes only the addressed register; all other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| ser_dat_i | input | 1 | Serial data |
| ser_clk_i | input | 1 | Serial clock, data taken on its rising edge |
| ser_le_i | input | 1 | Latch strobe: low while shifting, rising edge commits |
| cfg_regs_o | output | 448 | All sixteen registers, register n at bits n*28 +: 28 |
| soft_rst_o | output | 1 | One-cycle pulse after a soft-reset write |
| cal_start_o | output | 1 | One-cycle calibration-start pulse |

## Verification
The bench writes every address and checks the whole bank each time, so a swapped address nibble or a write into the wrong register shows up as a corrupted neighbour. It shifts an over-long stream and re-latches while clocking with the latch high. A design that keeps the first bits, or that shifts during the latch-high phase, would then commit a wrong word to some other address. Soft-reset and divider writes are paired with near misses: register 7 with bit 4 clear, and register 11 rewritten with an unchanged divider field. A design that decodes the wrong bit or fires on every divider write gives a wrong pulse count. Pulse widths are counted in system cycles, so a strobe held too long is reported as a second pulse.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = WORD_W - ADDR_W;
  localparam int NREG      = 1 << ADDR_W;
  localparam int RST_ADDR  = 7;
  localparam int RST_BIT   = 0;   // data bit 0 = word bit 4
  localparam int CAL_ADDR  = 15;
  localparam int NDIV_ADDR = 11;
  localparam int NDIV_LSB  = 0;
  localparam int NDIV_W    = 18;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [ADDR_W-1:0] addr_t;

  function automatic data_t reg_default(input int idx);
    data_t r;
    for (int k = 0; k < DATA_W / ADDR_W; k++) r[k*ADDR_W +: ADDR_W] = addr_t'(idx);
    return r;
  endfunction

  function automatic logic [NREG*DATA_W-1:0] flat_defaults();
    logic [NREG*DATA_W-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*DATA_W +: DATA_W] = reg_default(i);
    return f;
  endfunction

  function automatic logic is_reset_word(input addr_t a, input data_t d);
    return (a == addr_t'(RST_ADDR)) && d[RST_BIT];
  endfunction

  function automatic logic [NDIV_W-1:0] ndiv_field(input data_t d);
    return d[NDIV_LSB +: NDIV_W];
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sle_s,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic sclk_q, sle_q;
  logic shift_en;

  assign shift_en = sclk_s & ~sclk_q & ~sle_s;
  assign commit_o = sle_s & ~sle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sle_q  <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_q <= sclk_s;
      sle_q  <= sle_s;
      if (shift_en) word_o <= {word_o[WORD_W-2:0], sdat_s};
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic [WORD_W-1:0]      word_i,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   soft_rst_o,
  output logic                   cal_start_o
);
  data_t regs [NREG];
  addr_t waddr;
  data_t wdata;
  logic  rst_hit, cal_hit;

  assign waddr   = word_i[ADDR_W-1:0];
  assign wdata   = word_i[WORD_W-1:ADDR_W];
  assign rst_hit = commit_i && is_reset_word(waddr, wdata);
  assign cal_hit = commit_i && !rst_hit &&
                   ((waddr == addr_t'(CAL_ADDR)) ||
                    ((waddr == addr_t'(NDIV_ADDR)) &&
                     (ndiv_field(wdata) != ndiv_field(regs[NDIV_ADDR]))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(i);
      soft_rst_o  <= 1'b0;
      cal_start_o <= 1'b0;
    end else begin
      soft_rst_o  <= rst_hit;
      cal_start_o <= cal_hit;
      if (rst_hit) begin
        for (int i = 0; i < NREG; i++) regs[i] <= reg_default(i);
      end else if (commit_i) begin
        regs[waddr] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_dat_i,
  input  logic                   ser_clk_i,
  input  logic                   ser_le_i,
  output logic [NREG*DATA_W-1:0] cfg_regs_o,
  output logic                   soft_rst_o,
  output logic                   cal_start_o
);
  logic [2:0]        pins_s;
  logic              commit;
  logic [WORD_W-1:0] commit_word;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_le_i, ser_clk_i, ser_dat_i}),
    .q     (pins_s)
  );

  cfg_shifter i_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (pins_s[1]),
    .sdat_s   (pins_s[0]),
    .sle_s    (pins_s[2]),
    .word_o   (commit_word),
    .commit_o (commit)
  );

  cfg_bank i_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (commit),
    .word_i      (commit_word),
    .regs_o      (cfg_regs_o),
    .soft_rst_o  (soft_rst_o),
    .cal_start_o (cal_start_o)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
  import cfg_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   commit,
  input logic [WORD_W-1:0]      commit_word,
  input logic [NREG*DATA_W-1:0] regs_flat,
  input logic                   soft_rst,
  input logic                   cal_start
);
  logic rst_word;
  assign rst_word = (commit_word[ADDR_W-1:0] == addr_t'(RST_ADDR)) && commit_word[ADDR_W + RST_BIT];

  AST_STORE_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !rst_word |=> regs_flat[$past(commit_word[ADDR_W-1:0])*DATA_W +: DATA_W] == $past(commit_word[WORD_W-1:ADDR_W])); // R1
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> $past(commit) && $past(rst_word)); // R5
  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> regs_flat == flat_defaults()); // R5
  AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start); // R7
  AST_CAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> $past(commit)); // R8
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst); // R9
  AST_RST_NO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !cal_start); // R9
endmodule

bind cfg_serial_slave cfg_serial_slave_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit      (commit),
  .commit_word (commit_word),
  .regs_flat   (cfg_regs_o),
  .soft_rst    (soft_rst_o),
  .cal_start   (cal_start_o)
);

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SER   = 4;   // system cycles per serial half period
  localparam int NR = 16;
  localparam int DW = 28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sdat = 1'b0, sclk = 1'b0, sle = 1'b0;
  logic [NR*DW-1:0] regs;
  logic srst, cal;

  int checks = 0, fails = 0;
  int cal_cnt = 0, rst_cnt = 0;
  logic [DW-1:0] exp_r [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_slave i_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .ser_dat_i(sdat), .ser_clk_i(sclk), .ser_le_i(sle),
    .cfg_regs_o(regs), .soft_rst_o(srst), .cal_start_o(cal)
  );

  // count high cycles of each strobe, sampled away from the active edge
  always @(negedge clk) begin
    if (cal)  cal_cnt++;
    if (srst) rst_cnt++;
  end

  function automatic logic [DW-1:0] dflt(input int i);
    logic [3:0] n = i[3:0];
    return {n, n, n, n, n, n, n};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [63:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_clk(HALF_SER);
      sclk = 1'b1;
      wait_clk(HALF_SER);
      sclk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    wait_clk(HALF_SER);
    sle = 1'b1;
    wait_clk(8);
    sle = 1'b0;
    wait_clk(8);
  endtask

  task automatic write_word(input logic [31:0] w);
    send_bits({32'h0, w}, 32);
    pulse_latch();
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++)
      check(req, {4'h0, regs[i*DW +: DW]}, {4'h0, exp_r[i]});
  endtask

  task automatic t_reset();
    for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
    check_bank("R10 defaults");
    check("R10 soft_rst low", {31'h0, srst}, 32'h0);
    check("R10 cal low", {31'h0, cal}, 32'h0);
  endtask

  task automatic t_all_addr();
    for (int a = 0; a < NR; a++) begin
      logic [DW-1:0] d;
      int c0, r0;
      logic exp_cal;
      d = {a[3:0], ~a[3:0], 20'h5A5A5 + 20'(a)};
      if (a == 7) d[0] = 1'b0;
      exp_cal = (a == 15) || (a == 11 && d[17:0] != exp_r[11][17:0]);
      c0 = cal_cnt; r0 = rst_cnt;
      write_word({d, a[3:0]});
      exp_r[a] = d;
      check_bank("R1/R11 addressed write");
      check("R7/R8 cal count", cal_cnt - c0, {31'h0, exp_cal});
      if (a == 7) check("R6 no reset on bit4 clear", rst_cnt - r0, 0);
    end
  endtask

  task automatic t_msb_first();
    write_word(32'h8000_0003);
    exp_r[3] = 28'h800_0000;
    check_bank("R2 msb first");
  endtask

  task automatic t_overlong();
    send_bits({24'h0, 8'hFF, 28'h1234567, 4'h5}, 40);
    pulse_latch();
    exp_r[5] = 28'h1234567;
    check_bank("R4 last 32 bits");
  endtask

  task automatic t_latch_high_ignored();
    write_word({28'h0C0FFEE, 4'h2});
    exp_r[2] = 28'h0C0FFEE;
    sle = 1'b1;
    wait_clk(8);
    for (int i = 0; i < 6; i++) begin
      sdat = 1'b1;
      wait_clk(HALF_SER); sclk = 1'b1;
      wait_clk(HALF_SER); sclk = 1'b0;
    end
    sle = 1'b0;
    wait_clk(8);
    pulse_latch();
    check_bank("R3 latch-high clocks ignored");
  endtask

  task automatic t_ndiv();
    int c0;
    logic [DW-1:0] d;
    c0 = cal_cnt;
    d = {~exp_r[11][27:18], exp_r[11][17:0]};
    write_word({d, 4'd11});
    exp_r[11] = d;
    check("R8 unchanged divider no cal", cal_cnt - c0, 0);
    check_bank("R8 divider store");
    c0 = cal_cnt;
    d = exp_r[11] ^ 28'h0000001;
    write_word({d, 4'd11});
    exp_r[11] = d;
    check("R8 changed divider one cal", cal_cnt - c0, 1);
  endtask

  task automatic t_cal();
    int c0;
    c0 = cal_cnt;
    write_word({28'h0000ABC, 4'd15});
    check("R7 first cal write", cal_cnt - c0, 1);
    write_word({28'h0000ABC, 4'd15});
    check("R7 second cal write", cal_cnt - c0, 2);
    exp_r[15] = 28'h0000ABC;
  endtask

  task automatic t_soft_reset();
    int c0, r0;
    c0 = cal_cnt; r0 = rst_cnt;
    write_word({28'hFFFFFFF, 4'd7});
    for (int i = 0; i < NR; i++) exp_r[i] = dflt(i);
    check_bank("R5 defaults restored");
    check("R9 one reset pulse", rst_cnt - r0, 1);
    check("R9 no cal with reset", cal_cnt - c0, 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_all_addr();
    t_msb_first();
    t_overlong();
    t_latch_high_ignored();
    t_ndiv();
    t_cal();
    t_soft_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule